// File: doc/BRIEF.md
# USB Power-Up Sequencer

This block is a hardware state machine that brings up the PLL clock, the on-chip DC-DC supply and the USB function in a fixed order after a reset. It drives enables for the frequency synthesizer, the DC-DC converter and the 48 MHz USB clock, and a current-mode select for the converter. Once every step is complete it drives a final enable for the USB function control unit. Every delay is counted in cycles of the system clock. The tick counts come from the `CLK_HZ` parameter. The base unit is `U = CLK_HZ/10000` cycles, which is 0.1 ms.

The sequencer polls the PLL lock input at a fixed retry interval rather than making a single check. If lock keeps failing it raises a sticky error flag, and it keeps retrying. The supply-settle time comes from an external capacitance value on an input port. That value is in whole µF, or in tenths of a µF when `CAP_TENTHS=1`. Two byte-wide outputs give a register-style view of the control bits. A reset-pin filter ignores short low glitches. An invalid-opcode pulse restarts the sequence at once.

Top module: `usb_pwr_seq`

## Requirements
- R1: The reset pin restarts the sequence only after it has been sampled low on more than `RST_TICKS = CLK_HZ/500000` consecutive clock edges, i.e. 2 µs. A low pulse of `RST_TICKS` samples or fewer changes no output.
- R2: A one-cycle `bad_op` pulse drives all enables low on the next edge. The sequence then restarts: `pll_en` rises one edge after `bad_op` is sampled low.
- R3: While the sequencer is held in reset, every enable output and `busy` is low and both register views read 0 apart from the live lock bit. `pll_en` rises on the first edge at which the reset pin is sampled high.
- R4: With lock present, `dcdc_en` rises exactly `20*U+1` cycles after `pll_en` rises. This is the 2 ms wait plus the sampling cycle.
- R5: When lock is sampled low, it is sampled again every `U+1` cycles until it is seen high. `dcdc_en` rises on the edge that sees lock.
- R6: `lock_err` rises on the `LOCK_TRIES`-th failed lock sample. It stays set while retries go on, and only a restart clears it.
- R7: With `CAP_TENTHS=0`, `usb_clk_en` rises exactly `10*(C+1)*U` cycles after `dcdc_en`, which is (C+1) ms.
- R8: With `CAP_TENTHS=1`, the same delay is `(C+10)*U` cycles, with C in tenths of a µF. For example, 22 gives 3.2 ms.
- R9: `fcu_en` rises exactly `CLK_GAP` cycles after `usb_clk_en`, and `CLK_GAP` is at least 4.
- R10: `busy` is high from reset release until `fcu_en` rises. `done` is high for exactly one cycle, in the first cycle with `fcu_en` high.
- R11: `dcdc_lo` is 1 only while `suspend` is 1 and `fcu_en` is 1. Clearing `suspend` returns it to 0. `suspend` has no effect earlier in the sequence.
- R12: `syn_reg` holds `pll_en` in bit 0 and `pll_lock` in bit 7. `usb_reg` holds `dcdc_lo` in bit 3, `dcdc_en` in bit 4, `usb_clk_en` in bit 5 and `fcu_en` in bit 7. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_pin_n | input | 1 | Reset pin, active low, filtered |
| bad_op | input | 1 | Invalid-opcode restart pulse |
| pll_lock | input | 1 | PLL lock status, synchronous to clk |
| suspend | input | 1 | Bus suspend request |
| cap_val | input | CAP_W | External capacitance, in µF or tenths of a µF |
| pll_en | output | 1 | Frequency synthesizer enable |
| dcdc_en | output | 1 | DC-DC converter enable |
| dcdc_lo | output | 1 | Converter low-current mode |
| usb_clk_en | output | 1 | USB 48 MHz clock enable |
| fcu_en | output | 1 | USB function control unit enable |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| lock_err | output | 1 | Sticky lock-timeout flag |
| syn_reg | output | 8 | Synthesizer control view |
| usb_reg | output | 8 | USB control view |

## Verification
The bench builds the block with `CLK_HZ=1_000_000`, which gives `U=100` cycles and `RST_TICKS=2`. With these values a full bring-up with three lock failures takes about 5,300 cycles, so the exact-cycle edge timing can be checked across three sequences. `LOCK_TRIES=3` makes the sticky error reachable within a few retries. A second instance with `CAP_TENTHS=1` and `CAP_W=6` accepts the value 22 and so covers the 3.2 ms fractional settle delay.

// File: rtl/usb_pwr_seq.sv
module usb_pwr_seq #(
  parameter int CLK_HZ     = 24_000_000,
  parameter int CAP_W      = 4,
  parameter bit CAP_TENTHS = 1'b0,
  parameter int LOCK_TRIES = 8,
  parameter int CLK_GAP    = 4
) (
  input  logic             clk,
  input  logic             rst_pin_n,
  input  logic             bad_op,
  input  logic             pll_lock,
  input  logic             suspend,
  input  logic [CAP_W-1:0] cap_val,
  output logic             pll_en,
  output logic             dcdc_en,
  output logic             dcdc_lo,
  output logic             usb_clk_en,
  output logic             fcu_en,
  output logic             busy,
  output logic             done,
  output logic             lock_err,
  output logic [7:0]       syn_reg,
  output logic [7:0]       usb_reg
);
  localparam int RST_TICKS  = (CLK_HZ / 500_000 < 1) ? 1 : CLK_HZ / 500_000;
  localparam int UNIT_TICKS = (CLK_HZ / 10_000 < 1) ? 1 : CLK_HZ / 10_000;
  localparam int CAP_MAX    = (1 << CAP_W) - 1;
  localparam int SET_MAX    = CAP_TENTHS ? CAP_MAX + 10 : CAP_MAX * 10 + 10;
  localparam int UNIT_MAX   = (SET_MAX > 20) ? SET_MAX : 20;
  localparam int SUB_MAX    = (UNIT_TICKS > CLK_GAP) ? UNIT_TICKS : CLK_GAP;
  localparam int UW = $clog2(UNIT_MAX + 1);
  localparam int SW = $clog2(SUB_MAX + 1);
  localparam int RW = $clog2(RST_TICKS + 1);
  localparam int TW = $clog2(LOCK_TRIES + 1);

  typedef enum logic [2:0] {
    S_RST, S_PLL, S_POLL, S_RETRY, S_SETTLE, S_CLK, S_RUN
  } state_t;

  state_t         st, nxt;
  logic [RW-1:0]  lowcnt;
  logic [SW-1:0]  sub;
  logic [UW-1:0]  units;
  logic [TW-1:0]  fails;
  logic [UW-1:0]  settle;
  logic           restart, unit_end, cnt_en;

  assign restart  = bad_op | (!rst_pin_n && lowcnt == RW'(RST_TICKS));
  assign unit_end = (sub == SW'(UNIT_TICKS - 1));
  assign cnt_en   = st inside {S_PLL, S_RETRY, S_SETTLE, S_CLK};
  assign settle   = CAP_TENTHS ? UW'(cap_val) + UW'(10)
                               : UW'(cap_val) * UW'(10) + UW'(10);

  always_ff @(posedge clk) begin
    if (rst_pin_n) lowcnt <= '0;
    else if (lowcnt != RW'(RST_TICKS)) lowcnt <= lowcnt + RW'(1);
  end

  always_comb begin
    nxt = st;
    case (st)
      S_RST:    if (rst_pin_n) nxt = S_PLL;
      S_PLL:    if (unit_end && units == UW'(19)) nxt = S_POLL;
      S_POLL:   nxt = pll_lock ? S_SETTLE : S_RETRY;
      S_RETRY:  if (unit_end) nxt = S_POLL;
      S_SETTLE: if (unit_end && units == settle - UW'(1)) nxt = S_CLK;
      S_CLK:    if (sub == SW'(CLK_GAP - 1)) nxt = S_RUN;
      default:  nxt = st;
    endcase
    if (restart) nxt = S_RST;
  end

  always_ff @(posedge clk) begin
    st   <= nxt;
    done <= (st == S_CLK) && (nxt == S_RUN);
    if (nxt != st || !cnt_en) begin
      sub   <= '0;
      units <= '0;
    end else if (unit_end && st != S_CLK) begin
      sub   <= '0;
      units <= units + UW'(1);
    end else begin
      sub <= sub + SW'(1);
    end
    if (restart) begin
      fails    <= '0;
      lock_err <= 1'b0;
    end else if (st == S_POLL && !pll_lock) begin
      if (fails != TW'(LOCK_TRIES)) fails <= fails + TW'(1);
      if (fails == TW'(LOCK_TRIES - 1)) lock_err <= 1'b1;
    end
  end

  assign pll_en     = (st != S_RST);
  assign dcdc_en    = st inside {S_SETTLE, S_CLK, S_RUN};
  assign usb_clk_en = st inside {S_CLK, S_RUN};
  assign fcu_en     = (st == S_RUN);
  assign dcdc_lo    = fcu_en & suspend;
  assign busy       = (st != S_RST) && (st != S_RUN);
  assign syn_reg    = {pll_lock, 6'b0, pll_en};
  assign usb_reg    = {fcu_en, 1'b0, usb_clk_en, dcdc_en, dcdc_lo, 3'b0};
endmodule

// File: rtl/usb_pwr_seq_chk.sv
module usb_pwr_seq_chk (
  input logic clk,
  input logic rst_pin_n,
  input logic pll_lock,
  input logic suspend,
  input logic pll_en,
  input logic dcdc_en,
  input logic dcdc_lo,
  input logic usb_clk_en,
  input logic fcu_en,
  input logic busy,
  input logic done,
  input logic lock_err
);
  assert_dcdc_after_lock_R4: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $rose(dcdc_en) |-> $past(pll_lock) && pll_en);

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_pin_n)
    lock_err |=> lock_err || !pll_en);

  assert_clk_after_supply_R7: assert property (@(posedge clk) disable iff (!rst_pin_n)
    usb_clk_en |-> dcdc_en && pll_en);

  assert_fcu_gap_R9: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $rose(fcu_en) |-> $past(usb_clk_en, 4));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_pin_n)
    done |=> !done);

  assert_done_in_run_R10: assert property (@(posedge clk) disable iff (!rst_pin_n)
    done |-> fcu_en && !busy);

  assert_lowcur_run_only_R11: assert property (@(posedge clk) disable iff (!rst_pin_n)
    dcdc_lo |-> fcu_en && suspend);
endmodule

bind usb_pwr_seq usb_pwr_seq_chk chk (.*);

// File: tb/usb_pwr_seq_test.sv
`timescale 1ns/1ps
module usb_pwr_seq_test;
  logic clk = 1'b0;
  logic rst_pin_n = 1'b0, bad_op = 1'b0, pll_lock = 1'b0, suspend = 1'b0;
  logic [3:0] cap_a = 4'd2;
  logic [5:0] cap_b = 6'd22;
  logic pll_en, dcdc_en, dcdc_lo, usb_clk_en, fcu_en, busy, done, lock_err;
  logic [7:0] syn_reg, usb_reg;
  logic t_pll, t_dcdc, t_lo, t_clk, t_fcu, t_busy, t_done, t_err;
  logic [7:0] t_syn, t_usb;
  int cyc = 0, checks = 0, fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  usb_pwr_seq #(.CLK_HZ(1_000_000), .CAP_W(4), .CAP_TENTHS(1'b0), .LOCK_TRIES(3), .CLK_GAP(4)) uut (
    .clk, .rst_pin_n, .bad_op, .pll_lock, .suspend, .cap_val(cap_a),
    .pll_en, .dcdc_en, .dcdc_lo, .usb_clk_en, .fcu_en, .busy, .done, .lock_err, .syn_reg, .usb_reg);

  usb_pwr_seq #(.CLK_HZ(1_000_000), .CAP_W(6), .CAP_TENTHS(1'b1), .LOCK_TRIES(3), .CLK_GAP(4)) uut_t (
    .clk, .rst_pin_n, .bad_op, .pll_lock, .suspend, .cap_val(cap_b),
    .pll_en(t_pll), .dcdc_en(t_dcdc), .dcdc_lo(t_lo), .usb_clk_en(t_clk), .fcu_en(t_fcu),
    .busy(t_busy), .done(t_done), .lock_err(t_err), .syn_reg(t_syn), .usb_reg(t_usb));

  typedef struct { int code; int at; string req; } ev_t;
  ev_t q[$];
  string names[6] = '{"pll_en", "dcdc_en", "usb_clk_en", "fcu_en", "done", "lock_err"};

  task automatic expect_ev(input int code, input int at, input string req);
    ev_t e;
    e.code = code; e.at = at; e.req = req;
    q.push_back(e);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic got(input int code);
    ev_t e;
    checks++;
    if (q.size() == 0) begin
      fails++;
      $display("FAIL unexpected rise of %s: actual cycle=%0d expected none", names[code], cyc);
    end else begin
      e = q.pop_front();
      if (e.code != code || e.at != cyc) begin
        fails++;
        $display("FAIL %s: actual %s at %0d expected %s at %0d",
                 e.req, names[code], cyc, names[e.code], e.at);
      end
    end
  endtask

  logic [5:0] prev = '0;
  always @(negedge clk) begin
    logic [5:0] now;
    now = {lock_err, done, fcu_en, usb_clk_en, dcdc_en, pll_en};
    for (int i = 0; i < 6; i++)
      if (now[i] && !prev[i]) got(i);
    prev <= now;
  end

  task automatic at(input int n);
    @(negedge clk);
    while (cyc < n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (cyc > 20000 && !finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog (all requirements): actual cycle=%0d expected end before 20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // sequence 1: three failed lock samples
    expect_ev(0, 11, "R3");
    expect_ev(5, 2214, "R6");
    expect_ev(1, 2315, "R5");
    expect_ev(2, 5315, "R7");
    expect_ev(3, 5319, "R9");
    expect_ev(4, 5319, "R10");
    at(10);
    check("R3 reset pll_en", pll_en, 0);
    check("R3 reset busy", busy, 0);
    check("R3 reset usb_reg", usb_reg, 8'h00);
    check("R3 reset syn_reg", syn_reg, 8'h00);
    rst_pin_n = 1'b1;
    at(2100);
    check("R12 syn_reg waiting lock", syn_reg, 8'h01);
    check("R10 busy during poll", busy, 1);
    check("R5 converter off before lock", dcdc_en, 0);
    at(2300);
    pll_lock = 1'b1;
    check("R6 error sticky while retrying", lock_err, 1);
    at(2310);
    check("R12 syn_reg with lock", syn_reg, 8'h81);
    at(5318);
    check("R9 fcu not yet", fcu_en, 0);
    check("R10 busy before fcu", busy, 1);
    at(5320);
    check("R10 done one cycle", done, 0);
    check("R10 busy after fcu", busy, 0);
    check("R12 usb_reg running", usb_reg, 8'hB0);
    at(5514);
    check("R8 tenths clock not yet", t_clk, 0);
    at(5515);
    check("R8 tenths clock at 3.2 ms", t_clk, 1);
    at(5600);
    suspend = 1'b1;
    at(5601);
    check("R11 low current in suspend", dcdc_lo, 1);
    check("R12 usb_reg suspended", usb_reg, 8'hB8);
    at(5610);
    suspend = 1'b0;
    at(5611);
    check("R11 high current after suspend", dcdc_lo, 0);
    // short glitch ignored
    at(5700);
    rst_pin_n = 1'b0;
    at(5702);
    rst_pin_n = 1'b1;
    at(5710);
    check("R1 glitch fcu kept", fcu_en, 1);
    check("R1 glitch error kept", lock_err, 1);
    check("R1 glitch usb_reg kept", usb_reg, 8'hB0);
    // qualified reset
    at(5800);
    rst_pin_n = 1'b0;
    at(5802);
    check("R1 still running at 2 samples", fcu_en, 1);
    at(5803);
    check("R1 qualified reset fcu", fcu_en, 0);
    check("R1 qualified reset pll", pll_en, 0);
    check("R6 error cleared by restart", lock_err, 0);
    check("R3 busy in reset", busy, 0);
    cap_a = 4'd0;
    cap_b = 6'd5;
    expect_ev(0, 5811, "R1");
    expect_ev(1, 7812, "R4");
    expect_ev(2, 8812, "R7");
    expect_ev(3, 8816, "R9");
    expect_ev(4, 8816, "R10");
    at(5810);
    rst_pin_n = 1'b1;
    at(8000);
    suspend = 1'b1;
    at(8001);
    check("R11 suspend ignored while settling", dcdc_lo, 0);
    check("R12 usb_reg settling", usb_reg, 8'h10);
    check("R10 busy while settling", busy, 1);
    at(8005);
    suspend = 1'b0;
    // invalid opcode restart
    at(9000);
    bad_op = 1'b1;
    expect_ev(0, 9002, "R2");
    expect_ev(1, 11003, "R4");
    expect_ev(2, 12003, "R7");
    expect_ev(3, 12007, "R9");
    expect_ev(4, 12007, "R10");
    at(9001);
    check("R2 bad_op clears fcu", fcu_en, 0);
    check("R2 bad_op clears pll", pll_en, 0);
    check("R2 bad_op clears usb_reg", usb_reg, 8'h00);
    bad_op = 1'b0;
    at(12100);
    check("R7 all expected edges seen", q.size(), 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule